// File: doc/BRIEF.md
# Ramp-Test ADC Response Analyzer

This block sits beside an on-chip ADC during a self-test. A linear ramp sweeps the ADC input from below zero to above full scale, and the block watches the stream of output codes. The block finds the useful part of the sweep without help: it arms on a start pulse, waits for the first code that is not zero, and stops when the ADC reports its full-scale code. The two codes at those edges may be clipped, so both are dropped. Every code in between is added to one of two running sums, chosen by which half of the code range it falls in.

From the two sums the block forms two syndromes, their total and their difference. Later arithmetic, outside this block, turns these into the gain and offset of the converter. A sample count is also reported. The test ends with an error flag when too few samples were gathered for a usable estimate, or when full scale never arrives within a programmable number of samples. All results stay on the outputs until the next start pulse.

Top module: `ramp_adc_analyzer`

## Requirements
- R1: A start pulse clears both sums, both syndromes, the sample count, `done` and `errFlag`; one cycle after the pulse all of them read zero. Reset leaves the same state.
- R2: While armed, zero codes are ignored; the sample count and both sums stay zero.
- R3: The first non-zero code after a start is discarded; it is not summed and not counted.
- R4: Each later code other than full scale is counted once. A code whose most significant bit is 0 (below half scale, 2^(N-1)) is added to `lowSum`, any other code to `highSum`.
- R5: The full-scale code (all ones) while collecting ends the test: `done` goes high the next cycle and that code is neither summed nor counted.
- R6: `synTotal` equals `lowSum + highSum` and `synDiff` equals `highSum - lowSum` in two's complement of the sum width.
- R7: When the test ends on full scale, `errFlag` is high exactly when the count is below 2^(N-2).
- R8: Counting every valid sample since the start, when the sample number `timeoutLimit` arrives without full scale having been seen, the test ends with `done` and `errFlag` high; that sample is still summed if collection had begun. A full-scale code seen while still armed ends the test with `errFlag` high and a zero count.
- R9: Once `done` is high, all outputs hold and further samples are ignored until the next start pulse.
- R10: A code presented with `sampleValid` low has no effect, including the full-scale code.
- R11: A start pulse during a running test abandons it and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle pulse that clears results and arms a test |
| sampleValid | input | 1 | Strobe marking a new ADC code |
| sampleCode | input | ADC_BITS | ADC output code |
| timeoutLimit | input | TIMEOUT_BITS | Number of valid samples allowed before giving up |
| lowSum | output | 2*ADC_BITS+1 | Sum of codes in the lower half |
| highSum | output | 2*ADC_BITS+1 | Sum of codes in the upper half |
| synTotal | output | 2*ADC_BITS+1 | Sum of the two sums |
| synDiff | output | 2*ADC_BITS+1 | Upper sum minus lower sum, two's complement |
| sampleCount | output | TIMEOUT_BITS | Number of codes summed |
| done | output | 1 | Test finished |
| errFlag | output | 1 | Test finished with too few samples or timeout |

## Verification
The bench builds the block with a 6-bit code and a 10-bit timeout counter, so a whole ramp is only 63 codes and the bench can run many full sweeps, repeated codes and gapped strobes in a short run. With 6 bits the minimum sample count is 16, which lets the bench land exactly on and one below that boundary. The small timeout width lets a limit of 20 fire before the ramp reaches full scale.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARMED,
    PH_COLLECT,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic accLow;
    logic accHigh;
  } strobe_t;

endpackage

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int ADC_BITS = 8,
  parameter int SUM_BITS = 2 * ADC_BITS + 1,
  parameter int CNT_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [ADC_BITS-1:0] sampleCode,
  output logic [SUM_BITS-1:0] lowSum,
  output logic [SUM_BITS-1:0] highSum,
  output logic [SUM_BITS-1:0] synTotal,
  output logic [SUM_BITS-1:0] synDiff,
  output logic [CNT_BITS-1:0] sampleCount
);

  localparam int PAD_BITS = SUM_BITS - ADC_BITS;

  logic [SUM_BITS-1:0] codeWide;
  assign codeWide = {{PAD_BITS{1'b0}}, sampleCode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowSum      <= '0;
      highSum     <= '0;
      sampleCount <= '0;
    end else if (strb.clearAll) begin
      lowSum      <= '0;
      highSum     <= '0;
      sampleCount <= '0;
    end else begin
      if (strb.accLow)  lowSum  <= lowSum + codeWide;
      if (strb.accHigh) highSum <= highSum + codeWide;
      if (strb.accLow || strb.accHigh) sampleCount <= sampleCount + CNT_BITS'(1);
    end
  end

  always_comb begin
    synTotal = lowSum + highSum;
    synDiff  = highSum - lowSum;
  end

  // R4
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.accLow && !strb.clearAll) |=> $stable(lowSum));

  // R4
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.accHigh && !strb.clearAll) |=> $stable(highSum));

  // R4
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clearAll) |=> (sampleCount >= $past(sampleCount)));

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int ADC_BITS = 8,
  parameter int CNT_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startPulse,
  input  logic                sampleValid,
  input  logic [ADC_BITS-1:0] sampleCode,
  input  logic [CNT_BITS-1:0] timeoutLimit,
  input  logic [CNT_BITS-1:0] sampleCount,
  output strobe_t             strb,
  output logic                done,
  output logic                errFlag
);

  localparam logic [CNT_BITS-1:0] MIN_COUNT = CNT_BITS'(2 ** (ADC_BITS - 2));

  phase_t              phase, phaseNext;
  logic [CNT_BITS-1:0] seen, seenNext;
  logic                doneNext, errNext;
  logic [CNT_BITS:0]   seenInc;
  logic                timeUp, isMax, isZero, countShort;

  always_comb begin
    seenInc    = {1'b0, seen} + (CNT_BITS + 1)'(1);
    timeUp     = seenInc >= {1'b0, timeoutLimit};
    isMax      = sampleCode == '1;
    isZero     = sampleCode == '0;
    countShort = sampleCount < MIN_COUNT;
  end

  always_comb begin
    phaseNext = phase;
    seenNext  = seen;
    doneNext  = done;
    errNext   = errFlag;
    strb      = '0;
    if (startPulse) begin
      strb.clearAll = 1'b1;
      phaseNext     = PH_ARMED;
      seenNext      = '0;
      doneNext      = 1'b0;
      errNext       = 1'b0;
    end else if (sampleValid) begin
      unique case (phase)
        PH_ARMED: begin
          seenNext = seenInc[CNT_BITS-1:0];
          if (isMax) begin
            phaseNext = PH_DONE;
            doneNext  = 1'b1;
            errNext   = 1'b1;
          end else begin
            if (!isZero) phaseNext = PH_COLLECT;
            if (timeUp) begin
              phaseNext = PH_DONE;
              doneNext  = 1'b1;
              errNext   = 1'b1;
            end
          end
        end
        PH_COLLECT: begin
          seenNext = seenInc[CNT_BITS-1:0];
          if (isMax) begin
            phaseNext = PH_DONE;
            doneNext  = 1'b1;
            errNext   = countShort;
          end else begin
            strb.accLow  = !sampleCode[ADC_BITS-1];
            strb.accHigh = sampleCode[ADC_BITS-1];
            if (timeUp) begin
              phaseNext = PH_DONE;
              doneNext  = 1'b1;
              errNext   = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      seen    <= '0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      phase   <= phaseNext;
      seen    <= seenNext;
      done    <= doneNext;
      errFlag <= errNext;
    end
  end

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startPulse) |=> done);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startPulse) |-> (!strb.accLow && !strb.accHigh));

  // R5
  max_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COLLECT && sampleValid && isMax && !startPulse) |=> done);

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (!done && !errFlag));

endmodule

// File: rtl/ramp_adc_analyzer.sv
module ramp_adc_analyzer
  import ramp_pkg::*;
#(
  parameter int ADC_BITS     = 8,
  parameter int TIMEOUT_BITS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      startPulse,
  input  logic                      sampleValid,
  input  logic [ADC_BITS-1:0]       sampleCode,
  input  logic [TIMEOUT_BITS-1:0]   timeoutLimit,
  output logic [2*ADC_BITS:0]       lowSum,
  output logic [2*ADC_BITS:0]       highSum,
  output logic [2*ADC_BITS:0]       synTotal,
  output logic [2*ADC_BITS:0]       synDiff,
  output logic [TIMEOUT_BITS-1:0]   sampleCount,
  output logic                      done,
  output logic                      errFlag
);

  localparam int SUM_BITS = 2 * ADC_BITS + 1;

  strobe_t strb;

  ramp_ctrl #(
    .ADC_BITS (ADC_BITS),
    .CNT_BITS (TIMEOUT_BITS)
  ) ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .startPulse   (startPulse),
    .sampleValid  (sampleValid),
    .sampleCode   (sampleCode),
    .timeoutLimit (timeoutLimit),
    .sampleCount  (sampleCount),
    .strb         (strb),
    .done         (done),
    .errFlag      (errFlag)
  );

  ramp_datapath #(
    .ADC_BITS (ADC_BITS),
    .SUM_BITS (SUM_BITS),
    .CNT_BITS (TIMEOUT_BITS)
  ) dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .sampleCode  (sampleCode),
    .lowSum      (lowSum),
    .highSum     (highSum),
    .synTotal    (synTotal),
    .synDiff     (synDiff),
    .sampleCount (sampleCount)
  );

endmodule

// File: tb/ramp_adc_analyzer_test.sv
module ramp_adc_analyzer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB  = 6;
  localparam int TB  = 10;
  localparam int SB  = 2 * NB + 1;
  localparam int MAXC = (1 << NB) - 1;
  localparam int HALF = 1 << (NB - 1);
  localparam int MINC = 1 << (NB - 2);

  typedef struct {
    logic [SB-1:0] lo, hi, tot, dif;
    logic [TB-1:0] cnt;
    logic          err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startPulse = 1'b0;
  logic sampleValid = 1'b0;
  logic [NB-1:0] sampleCode = '0;
  logic [TB-1:0] timeoutLimit = TB'(1000);
  logic [SB-1:0] lowSum, highSum, synTotal, synDiff;
  logic [TB-1:0] sampleCount;
  logic done, errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t expQ[$];
  int stim[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ramp_adc_analyzer #(.ADC_BITS(NB), .TIMEOUT_BITS(TB)) uut (
    .clk, .rst_n, .startPulse, .sampleValid, .sampleCode, .timeoutLimit,
    .lowSum, .highSum, .synTotal, .synDiff, .sampleCount, .done, .errFlag
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // model of the requirements; pushes an expected record if the test ends
  task automatic modelRun(input int limit);
    int phase = 0;
    int seen = 0;
    longint lo = 0, hi = 0;
    int cnt = 0;
    bit fin = 0, err = 0;
    exp_t e;
    foreach (stim[i]) begin
      if (fin) break;
      seen++;
      if (phase == 0) begin
        if (stim[i] == MAXC) begin fin = 1; err = 1; end   // R8 armed full scale
        else begin
          if (stim[i] != 0) phase = 1;                       // R2, R3
          if (seen >= limit) begin fin = 1; err = 1; end     // R8
        end
      end else begin
        if (stim[i] == MAXC) begin fin = 1; err = (cnt < MINC); end  // R5, R7
        else begin
          if (stim[i] < HALF) lo += stim[i]; else hi += stim[i];     // R4
          cnt++;
          if (seen >= limit) begin fin = 1; err = 1; end             // R8
        end
      end
    end
    if (fin) begin
      e.lo = SB'(lo); e.hi = SB'(hi);
      e.tot = SB'(lo + hi); e.dif = SB'(hi - lo);
      e.cnt = TB'(cnt); e.err = err;
      expQ.push_back(e);
    end
  endtask

  // drive the stimulus; gap cycles present full scale with valid low (R10)
  task automatic driveStim(input bit gaps);
    foreach (stim[i]) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleCode  = NB'(stim[i]);
      if (gaps) begin
        @(negedge clk);
        sampleValid = 1'b0;
        sampleCode  = NB'(MAXC);
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
    sampleCode  = '0;
  endtask

  task automatic runTest(input int limit, input bit gaps);
    modelRun(limit);
    @(negedge clk);
    timeoutLimit = TB'(limit);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R1 / R11: cleared one cycle after the start pulse
    chk(sampleCount == 0 && lowSum == 0 && highSum == 0, "R1 clear sums",
        sampleCount + lowSum + highSum, 0);
    chk(!done && !errFlag, "R1 clear flags", {done, errFlag}, 0);
    driveStim(gaps);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares results when done rises
  initial begin
    bit doneSeen = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (done && !doneSeen) begin
        doneSeen = 1;
        if (expQ.size() == 0) chk(0, "R5 unexpected done", 1, 0);
        else begin
          e = expQ.pop_front();
          chk(lowSum == e.lo, "R4 lowSum", lowSum, e.lo);
          chk(highSum == e.hi, "R4 highSum", highSum, e.hi);
          chk(sampleCount == e.cnt, "R3 sampleCount", sampleCount, e.cnt);
          chk(synTotal == e.tot, "R6 synTotal", synTotal, e.tot);
          chk(synDiff == e.dif, "R6 synDiff", synDiff, e.dif);
          chk(errFlag == e.err, "R7 errFlag", errFlag, e.err);
        end
      end else if (!done) doneSeen = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [SB-1:0] hLo, hHi;
    logic [TB-1:0] hCnt;
    logic hErr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !errFlag && sampleCount == 0 && lowSum == 0 && synTotal == 0,
        "R1 reset state", {done, errFlag, sampleCount}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: single full ramp
    stim.delete();
    stim.push_back(0); stim.push_back(0); stim.push_back(0);
    for (int c = 1; c <= MAXC; c++) stim.push_back(c);
    runTest(1000, 0);

    // R9: results hold and samples are ignored after done
    hLo = lowSum; hHi = highSum; hCnt = sampleCount; hErr = errFlag;
    stim.delete();
    for (int c = 5; c < 40; c += 3) stim.push_back(c);
    driveStim(0);
    chk(done && lowSum == hLo && highSum == hHi && sampleCount == hCnt && errFlag == hErr,
        "R9 hold after done", {lowSum, highSum}, {hLo, hHi});

    // R10 R4: each code twice, with gapped strobes carrying full scale
    stim.delete();
    stim.push_back(0); stim.push_back(0);
    for (int c = 1; c <= MAXC; c++) begin stim.push_back(c); stim.push_back(c); end
    runTest(1000, 1);

    // R7: too few samples
    stim.delete();
    stim.push_back(0); stim.push_back(1);
    for (int c = 40; c <= 45; c++) stim.push_back(c);
    stim.push_back(MAXC);
    runTest(1000, 0);

    // R7: exactly the minimum, crossing half scale
    stim.delete();
    stim.push_back(0); stim.push_back(5);
    for (int c = 24; c < 24 + MINC; c++) stim.push_back(c);
    stim.push_back(MAXC);
    runTest(1000, 0);

    // R7: one below the minimum
    stim.delete();
    stim.push_back(0); stim.push_back(5);
    for (int c = 24; c < 24 + MINC - 1; c++) stim.push_back(c);
    stim.push_back(MAXC);
    runTest(1000, 0);

    // R8: timeout before full scale
    stim.delete();
    stim.push_back(0); stim.push_back(0);
    for (int c = 1; c <= 40; c++) stim.push_back(c);
    runTest(20, 0);

    // R8: full scale while still armed
    stim.delete();
    stim.push_back(0); stim.push_back(0); stim.push_back(MAXC);
    runTest(1000, 0);

    // R11: abandon a partial run, then a full ramp
    stim.delete();
    stim.push_back(0);
    for (int c = 1; c <= 20; c++) stim.push_back(c);
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    driveStim(0);
    chk(!done && sampleCount == 19, "R11 partial run counting", sampleCount, 19);
    stim.delete();
    for (int c = 1; c <= MAXC; c += 2) stim.push_back(c);
    runTest(1000, 0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 all results seen", expQ.size(), 0);
    summary();
  end

endmodule